// File: doc/BRIEF.md
# Dual Channel Serial DAC Loader

This block takes a pair of 16-bit words through a valid/ready handshake and writes them to two serial DAC inputs at the same time. Both data lines share one serial clock and one active-low frame strobe. The two lines change on the same clock edges, so both words arrive within a single frame.

When the frame ends, the strobe returns high and the block waits a short gap. It then drives an active-low load strobe for one serial clock period, and both DAC outputs update at that moment. The block holds `in_ready` low from the cycle after it accepts a pair until the load strobe ends. Only after that can it take the next pair.

The system clock is divided down to make the serial clock. `HALF_CYC` system cycles form one half of a serial clock period. With a 100 MHz system clock, the default of 5 gives a 10 MHz serial clock. Timing below is written in units of H = `HALF_CYC` system cycles. Cycle 0 is the first cycle after the edge that accepts a pair.

Top module: `dual_dac_loader`

## Requirements
- R1: After reset, and whenever no transfer is running: `in_ready` is 1, `dac_sync_n`, `dac_sclk` and `dac_ldac_n` are 1, and both data lines are 0.
- R2: A pair is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle through cycle 36H-1.
- R3: `dac_sync_n` is 0 in exactly cycles 0 to 32H-1 after acceptance, and is 1 at all other times.
- R4: `dac_sclk` is 1 during the first half and 0 during the second half of each bit period. A bit period is 2H cycles. `dac_sclk` is 1 whenever `dac_sync_n` is 1.
- R5: In bit period k (k = 0..15), the data lines carry bit 15-k of their words, so the most significant bit goes first. A bit changes only when the serial clock rises, which is half a period before the falling sampling edge.
- R6: `dac_din_a` carries `word_a` and `dac_din_b` carries `word_b`. Both lines change on the same cycles.
- R7: After the frame, `dac_sync_n` and `dac_sclk` stay 1 for cycles 32H to 34H-1 while `dac_ldac_n` stays 1. `dac_ldac_n` is never 0 while `dac_sync_n` is 0.
- R8: `dac_ldac_n` is 0 in exactly cycles 34H to 36H-1. `in_ready` returns to 1 in cycle 36H.
- R9: Changes on `word_a`, `word_b` or `in_valid` while `in_ready` is 0 have no effect on the serial outputs.
- R10: If `in_valid` is held at 1, the next pair is accepted on the first edge where `in_ready` is 1, and its frame begins in the cycle after that edge.
- R11: Both data lines are 0 whenever `dac_sync_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word pair valid |
| in_ready | output | 1 | Block can accept a word pair |
| word_a | input | WORD_W | Word for channel A |
| word_b | input | WORD_W | Word for channel B |
| dac_sclk | output | 1 | Shared serial clock; high when no frame is running |
| dac_sync_n | output | 1 | Active-low frame strobe |
| dac_din_a | output | 1 | Serial data, channel A |
| dac_din_b | output | 1 | Serial data, channel B |
| dac_ldac_n | output | 1 | Active-low load strobe |

## Verification
The bench builds the block with `WORD_W` = 16 and `HALF_CYC` = 3. Each half period then spans several system cycles, so the divider's wrap and the hold of each output inside a half period are exercised. A full transfer takes 108 cycles, which leaves room for many frames: all-ones and all-zeros words, alternating patterns, and words that differ only in the end bits. It also reaches inputs that change while the block is busy, and a second pair accepted in the very cycle `in_ready` returns.

// File: rtl/dual_dac_loader.sv
module dual_dac_loader #(
  parameter int WORD_W   = 16,
  parameter int HALF_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic              dac_sclk,
  output logic              dac_sync_n,
  output logic              dac_din_a,
  output logic              dac_din_b,
  output logic              dac_ldac_n
);

  localparam int DW        = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int HW        = $clog2(2 * WORD_W);
  localparam int LAST_HALF = 2 * WORD_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_LOAD} state_t;

  state_t            state;
  logic [DW-1:0]     div;
  logic [HW-1:0]     half;
  logic [WORD_W-1:0] sh_a, sh_b;
  logic              half_end;

  assign half_end   = (div == DW'(HALF_CYC - 1));
  assign in_ready   = (state == S_IDLE);
  assign dac_sync_n = (state != S_SHIFT);
  assign dac_sclk   = !((state == S_SHIFT) && half[0]);
  assign dac_ldac_n = (state != S_LOAD);
  assign dac_din_a  = sh_a[WORD_W-1];
  assign dac_din_b  = sh_b[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      div   <= '0;
      half  <= '0;
      sh_a  <= '0;
      sh_b  <= '0;
    end else begin
      if (state == S_IDLE) begin
        div  <= '0;
        half <= '0;
        if (in_valid) begin
          sh_a  <= word_a;
          sh_b  <= word_b;
          state <= S_SHIFT;
        end
      end else begin
        div <= half_end ? '0 : div + 1'b1;
        if (half_end) begin
          case (state)
            S_SHIFT: begin
              if (half[0]) begin
                sh_a <= sh_a << 1;
                sh_b <= sh_b << 1;
              end
              if (half == HW'(LAST_HALF)) begin
                half  <= '0;
                state <= S_GAP;
              end else begin
                half <= half + 1'b1;
              end
            end
            S_GAP: begin
              if (half[0]) begin
                half  <= '0;
                state <= S_LOAD;
              end else begin
                half <= half + 1'b1;
              end
            end
            default: begin
              if (half[0]) begin
                half  <= '0;
                state <= S_IDLE;
              end else begin
                half <= half + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2
  AST_FRAME_STARTS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sync_n) |-> $past(in_valid && in_ready)); // R3
  AST_SCLK_HIGH_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sync_n |-> dac_sclk); // R4
  AST_DATA_STABLE_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sclk) |-> ($stable(dac_din_a) && $stable(dac_din_b))); // R5
  AST_LOAD_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ldac_n |-> (dac_sync_n && dac_sclk)); // R7
  AST_LOAD_FOLLOWS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_ldac_n) |-> $past(dac_sync_n)); // R7
  AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_ldac_n) |-> in_ready); // R8
  AST_DATA_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sync_n |-> (!dac_din_a && !dac_din_b)); // R11

endmodule

// File: tb/test_dual_dac_loader.sv
`timescale 1ns/1ps
module test_dual_dac_loader;
  localparam int W = 16;
  localparam int H = 3;
  localparam int TOTAL = 36 * H;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [W-1:0] word_a = '0, word_b = '0;
  logic in_ready, dac_sclk, dac_sync_n, dac_din_a, dac_din_b, dac_ldac_n;

  int n_checks = 0, n_fail = 0, cycles = 0;
  int t = -1;
  logic [W-1:0] m_a = '0, m_b = '0;
  string tag = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  dual_dac_loader #(.WORD_W(W), .HALF_CYC(H)) i_dual_dac_loader (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .word_a(word_a), .word_b(word_b), .dac_sclk(dac_sclk), .dac_sync_n(dac_sync_n),
    .dac_din_a(dac_din_a), .dac_din_b(dac_din_b), .dac_ldac_n(dac_ldac_n));

  // reference model: t counts cycles since acceptance, -1 when idle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) t = -1;
    else if (t < 0) begin
      if (in_valid) begin t = 0; m_a = word_a; m_b = word_b; end
    end else if (t == TOTAL - 1) t = -1;
    else t = t + 1;
  end

  task automatic chk(input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at t=%0d: actual %b expected %b", tag, what, t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic e_rdy, e_sync, e_sclk, e_ldac, e_a, e_b;
    int k;
    e_rdy = (t < 0);
    e_sync = !(t >= 0 && t < 32 * H);
    e_sclk = e_sync ? 1'b1 : (((t / H) % 2) == 0);
    e_ldac = !(t >= 34 * H && t < 36 * H);
    e_a = 1'b0; e_b = 1'b0;
    if (!e_sync) begin
      k = t / (2 * H);
      e_a = m_a[W-1-k];
      e_b = m_b[W-1-k];
    end
    chk(in_ready, e_rdy, "R2 R8 R10 in_ready");
    chk(dac_sync_n, e_sync, "R3 dac_sync_n");
    chk(dac_sclk, e_sclk, "R4 dac_sclk");
    chk(dac_ldac_n, e_ldac, "R7 R8 dac_ldac_n");
    chk(dac_din_a, e_a, "R5 R6 R11 dac_din_a");
    chk(dac_din_b, e_b, "R5 R6 R11 dac_din_b");
  end

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input bit scramble);
    while (!in_ready) @(negedge clk);
    word_a = a; word_b = b; in_valid = 1;
    @(negedge clk);
    if (!scramble) in_valid = 0;
    while (!in_ready) begin
      if (scramble) begin word_a = word_a * 16'd3 + 16'h1357; word_b = ~word_b ^ word_a; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    tag = "R5"; send(16'hA5C3, 16'h3C5A, 0);
    tag = "R6"; send(16'hFFFF, 16'h0000, 0);
    send(16'h8001, 16'h7FFE, 0);
    tag = "R9"; send(16'h1234, 16'hFEDC, 1);
    tag = "R10"; word_a = 16'h0F0F; word_b = 16'hF0F0;
    @(negedge clk); in_valid = 0;
    while (!in_ready) @(negedge clk);
    tag = "R1"; repeat (6) @(negedge clk);
    done = 1;
  end

  initial begin
    while (!done && cycles < 20000) begin @(posedge clk); cycles++; end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule